// File: doc/BRIEF.md
# Halt, Wake-up and Reset-Cause Sequencer

This block decides when a small processor may sleep and how it comes back. A halt command from the core stops the system oscillator and the CPU. While the core sleeps, the block watches four kinds of event: an external reset request, a watchdog overflow, a newly raised interrupt request, and a falling edge on an enabled port pin. The watchdog clock is not controlled here and keeps running.

Once a wake event is seen, the oscillator is restarted at once. The CPU is held for a fixed stabilisation period of `DELAY_CYC` system clocks, 1024 by default. The block then spends one resume cycle in which it may raise a warm-reset pulse or a take-the-vector pulse, and after that the CPU runs. Which path is taken depends on the event: a plain continue, a jump to the interrupt vector, or a warm reset.

Two status flags, timeout and power-down, record the cause of the most recent reset or wake so that software can read them. The core itself and interrupt priority resolution are outside this block.

Top module: `halt_wake_ctrl`

## Requirements
- R1: A halt command in the running state is accepted unless a watchdog overflow arrives in the same cycle. On the clock edge that accepts it, the oscillator enable and the CPU run enable both go low, the power-down flag goes to 1 and the timeout flag goes to 0.
- R2: A watchdog clear command in the running state clears the power-down flag and leaves the timeout flag unchanged. If a halt command is accepted in the same cycle, the halt takes precedence.
- R3: A watchdog overflow in the running state sets the timeout flag and leaves the power-down flag unchanged. If it coincides with a halt command, the halt is not taken and the CPU keeps running.
- R4: An external reset request in the running state has no effect on this block: the flags and the run enable are unchanged.
- R5: While halted, the wake sources are ranked as follows: external reset first, then watchdog overflow, then interrupt, then port edge. A wake caused by an external reset leaves the flags at timeout=0, power-down=1.
- R6: A watchdog wake leaves the flags at timeout=1, power-down=1. It raises the warm-reset output for exactly one cycle, in the resume cycle.
- R7: A port wake is a falling edge (the previous cycle's registered pin at 1, the current pin at 0) on a first-port pin whose own enable bit is 1, or on any pin of a further port whose single group enable bit is 1. Edges on disabled pins, and all rising edges, leave the block halted.
- R8: An interrupt request that is already high on the edge that accepts the halt cannot wake the block for the rest of that halt. A request bit that rises later does wake it.
- R9: On an interrupt wake, the vector-take output pulses in the resume cycle only if, in the wake cycle, a newly raised request has its enable bit set and the stack-full input is low. Otherwise the CPU simply continues, with neither pulse.
- R10: Counting the wake edge as edge 0, the oscillator enable is high and the CPU run enable is low from edge 0 onward. The resume cycle follows edge `DELAY_CYC`, and the CPU run enable rises at edge `DELAY_CYC`+1.
- R11: A power-on reset gives the flags timeout=0, power-down=0, the running state with oscillator and CPU enabled, and no pulses.
- R12: The warm-reset and vector-take pulses are never high together, and the CPU runs in the cycle after either one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| por_i | input | 1 | Power-on reset, synchronous, active high |
| ext_rst_i | input | 1 | External reset request |
| halt_cmd_i | input | 1 | Halt command from the core |
| wdt_clr_i | input | 1 | Watchdog clear command from the core |
| wdt_ovf_i | input | 1 | Watchdog overflow |
| irq_req_i | input | IRQ_N | Interrupt request flags |
| irq_en_i | input | IRQ_N | Interrupt enable bits |
| stack_full_i | input | 1 | Return stack is full |
| pa_i | input | PA_W | First port pins |
| pa_wake_en_i | input | PA_W | Per-pin wake enables of the first port |
| pg_i | input | PG_N*PG_W | Pins of the further ports, with port g in bits g*PG_W upward |
| pg_wake_en_i | input | PG_N | One wake enable per further port |
| sys_osc_en_o | output | 1 | System oscillator enable |
| cpu_run_o | output | 1 | CPU may execute |
| warm_rst_o | output | 1 | One-cycle warm reset of program counter and stack pointer |
| irq_take_o | output | 1 | One-cycle request to take the interrupt vector |
| flag_to_o | output | 1 | Timeout flag |
| flag_pd_o | output | 1 | Power-down flag |

## Verification
Two cases let competing functions land on the same clock edge. In the running state, a halt command can meet a watchdog overflow; the overflow must win, so the CPU keeps running and the timeout flag rises. While halted, an external reset, a watchdog overflow, a new interrupt and a pin edge can all appear in one wake cycle. The random phase draws each of these independently, so such overlaps occur often, and a bench function ranks the sources to predict which pulse appears, which flag pair results and whether the block stays asleep. Directed cases force the two-source collision in both states, and then judge the outcome from the run enable, the pulses and the flags.

// File: rtl/hwc_pkg.sv
package hwc_pkg;

    typedef enum logic [1:0] {
        ST_RUN        = 2'd0,
        ST_HALT       = 2'd1,
        ST_WAKE_DELAY = 2'd2,
        ST_RESUME     = 2'd3
    } hwc_state_e;

    typedef enum logic [2:0] {
        WK_NONE     = 3'd0,
        WK_EXT      = 3'd1,
        WK_WDT      = 3'd2,
        WK_IRQ_VEC  = 3'd3,
        WK_CONTINUE = 3'd4
    } hwc_wake_e;

    typedef struct packed {
        logic halt_enter;
        logic run_wdt;
        logic run_clr;
        logic wake_ext;
        logic wake_wdt;
    } hwc_flag_cmd_t;

    // Ranked wake source selection: reset, watchdog, interrupt, port.
    function automatic hwc_wake_e hwc_pick_wake(input logic ext,
                                                input logic wdt,
                                                input logic irq_any,
                                                input logic irq_vec,
                                                input logic port_any);
        hwc_wake_e w;
        if (ext)           w = WK_EXT;
        else if (wdt)      w = WK_WDT;
        else if (irq_any)  w = irq_vec ? WK_IRQ_VEC : WK_CONTINUE;
        else if (port_any) w = WK_CONTINUE;
        else               w = WK_NONE;
        return w;
    endfunction

endpackage

// File: rtl/hwc_wake_detect.sv
module hwc_wake_detect
    import hwc_pkg::*;
#(
    parameter int IRQ_N = 4,
    parameter int PA_W  = 8,
    parameter int PG_N  = 3,
    parameter int PG_W  = 8
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 capture_i,
    input  logic                 armed_i,
    input  logic                 ext_rst_i,
    input  logic                 wdt_ovf_i,
    input  logic [IRQ_N-1:0]     irq_req_i,
    input  logic [IRQ_N-1:0]     irq_en_i,
    input  logic                 stack_full_i,
    input  logic [PA_W-1:0]      pa_i,
    input  logic [PA_W-1:0]      pa_en_i,
    input  logic [PG_N*PG_W-1:0] pg_i,
    input  logic [PG_N-1:0]      pg_en_i,
    output logic                 wake_o,
    output hwc_wake_e            cause_o
);
    localparam int PG_BITS = PG_N * PG_W;

    logic [PA_W-1:0]    pa_q;
    logic [PG_BITS-1:0] pg_q;
    logic [IRQ_N-1:0]   pend_q;
    logic [PG_N-1:0]    grp_fall;
    logic [IRQ_N-1:0]   irq_new;
    logic               pa_fall_any;
    logic               port_any;
    logic               irq_vec;

    always_ff @(posedge clk) begin
        if (rst) begin
            pa_q   <= '0;
            pg_q   <= '0;
            pend_q <= '0;
        end else begin
            pa_q <= pa_i;
            pg_q <= pg_i;
            if (capture_i) pend_q <= irq_req_i;
        end
    end

    for (genvar g = 0; g < PG_N; g++) begin : g_grp
        assign grp_fall[g] = pg_en_i[g] & (|(pg_q[g*PG_W +: PG_W] & ~pg_i[g*PG_W +: PG_W]));
    end

    assign pa_fall_any = |(pa_q & ~pa_i & pa_en_i);
    assign port_any    = pa_fall_any | (|grp_fall);
    assign irq_new     = irq_req_i & ~pend_q;
    assign irq_vec     = (|(irq_new & irq_en_i)) & ~stack_full_i;

    always_comb begin
        cause_o = hwc_pick_wake(ext_rst_i, wdt_ovf_i, |irq_new, irq_vec, port_any);
        wake_o  = armed_i && (cause_o != WK_NONE);
    end

    // R8: requests pending since halt entry alone never wake
    p_pending_masked_r8: assert property (@(posedge clk) disable iff (rst)
        (armed_i && $past(armed_i) && (irq_req_i == pend_q) && !ext_rst_i && !wdt_ovf_i && !port_any)
        |-> !wake_o);

    // R5: external reset outranks every other source
    p_ext_first_r5: assert property (@(posedge clk) disable iff (rst)
        (armed_i && ext_rst_i) |-> (wake_o && cause_o == WK_EXT));

endmodule

// File: rtl/hwc_delay_timer.sv
module hwc_delay_timer #(
    parameter int DELAY_CYC = 1024
) (
    input  logic clk,
    input  logic rst,
    input  logic load_i,
    output logic done_o
);
    localparam int CNT_W = (DELAY_CYC > 1) ? $clog2(DELAY_CYC) : 1;
    localparam logic [CNT_W-1:0] LOAD_VAL = CNT_W'(DELAY_CYC - 1);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst)                  cnt_q <= '0;
        else if (load_i)          cnt_q <= LOAD_VAL;
        else if (cnt_q != '0)     cnt_q <= cnt_q - CNT_W'(1);
    end

    assign done_o = (cnt_q == '0);

    // R10: the stabilisation count only moves downward by one
    p_count_down_r10: assert property (@(posedge clk) disable iff (rst)
        (!load_i && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - CNT_W'(1)));

endmodule

// File: rtl/hwc_cause_flags.sv
module hwc_cause_flags
    import hwc_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  hwc_flag_cmd_t cmd_i,
    output logic          to_o,
    output logic          pd_o
);
    always_ff @(posedge clk) begin
        if (rst) begin
            to_o <= 1'b0;
            pd_o <= 1'b0;
        end else begin
            if (cmd_i.halt_enter)                        to_o <= 1'b0;
            else if (cmd_i.wake_wdt || cmd_i.run_wdt)    to_o <= 1'b1;
            else if (cmd_i.wake_ext)                     to_o <= 1'b0;

            if (cmd_i.halt_enter)                        pd_o <= 1'b1;
            else if (cmd_i.run_clr)                      pd_o <= 1'b0;
        end
    end

    // R6: a watchdog wake leaves the flag pair at 1,1
    p_wdt_wake_flags_r6: assert property (@(posedge clk) disable iff (rst)
        cmd_i.wake_wdt |=> (to_o && pd_o));

    // R5: an external-reset wake leaves the flag pair at 0,1
    p_ext_wake_flags_r5: assert property (@(posedge clk) disable iff (rst)
        (cmd_i.wake_ext && $past(pd_o)) |=> (!to_o && pd_o));

endmodule

// File: rtl/halt_wake_ctrl.sv
module halt_wake_ctrl
    import hwc_pkg::*;
#(
    parameter int IRQ_N     = 4,
    parameter int PA_W      = 8,
    parameter int PG_N      = 3,
    parameter int PG_W      = 8,
    parameter int DELAY_CYC = 1024
) (
    input  logic                 clk,
    input  logic                 por_i,
    input  logic                 ext_rst_i,
    input  logic                 halt_cmd_i,
    input  logic                 wdt_clr_i,
    input  logic                 wdt_ovf_i,
    input  logic [IRQ_N-1:0]     irq_req_i,
    input  logic [IRQ_N-1:0]     irq_en_i,
    input  logic                 stack_full_i,
    input  logic [PA_W-1:0]      pa_i,
    input  logic [PA_W-1:0]      pa_wake_en_i,
    input  logic [PG_N*PG_W-1:0] pg_i,
    input  logic [PG_N-1:0]      pg_wake_en_i,
    output logic                 sys_osc_en_o,
    output logic                 cpu_run_o,
    output logic                 warm_rst_o,
    output logic                 irq_take_o,
    output logic                 flag_to_o,
    output logic                 flag_pd_o
);
    hwc_state_e    state_q, state_d;
    hwc_wake_e     cause_q, det_cause;
    hwc_flag_cmd_t fcmd;
    logic          det_wake, halt_go, wake, tmr_done;

    hwc_wake_detect #(
        .IRQ_N(IRQ_N), .PA_W(PA_W), .PG_N(PG_N), .PG_W(PG_W)
    ) u_detect (
        .clk          (clk),
        .rst          (por_i),
        .capture_i    (halt_go),
        .armed_i      (state_q == ST_HALT),
        .ext_rst_i    (ext_rst_i),
        .wdt_ovf_i    (wdt_ovf_i),
        .irq_req_i    (irq_req_i),
        .irq_en_i     (irq_en_i),
        .stack_full_i (stack_full_i),
        .pa_i         (pa_i),
        .pa_en_i      (pa_wake_en_i),
        .pg_i         (pg_i),
        .pg_en_i      (pg_wake_en_i),
        .wake_o       (det_wake),
        .cause_o      (det_cause)
    );

    hwc_delay_timer #(.DELAY_CYC(DELAY_CYC)) u_timer (
        .clk    (clk),
        .rst    (por_i),
        .load_i (wake),
        .done_o (tmr_done)
    );

    assign halt_go = (state_q == ST_RUN) && halt_cmd_i && !wdt_ovf_i;
    assign wake    = det_wake;

    always_comb begin
        fcmd.halt_enter = halt_go;
        fcmd.run_wdt    = (state_q == ST_RUN) && wdt_ovf_i;
        fcmd.run_clr    = (state_q == ST_RUN) && wdt_clr_i;
        fcmd.wake_ext   = wake && (det_cause == WK_EXT);
        fcmd.wake_wdt   = wake && (det_cause == WK_WDT);
    end

    hwc_cause_flags u_flags (
        .clk   (clk),
        .rst   (por_i),
        .cmd_i (fcmd),
        .to_o  (flag_to_o),
        .pd_o  (flag_pd_o)
    );

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_RUN:        if (halt_go)  state_d = ST_HALT;
            ST_HALT:       if (wake)     state_d = ST_WAKE_DELAY;
            ST_WAKE_DELAY: if (tmr_done) state_d = ST_RESUME;
            ST_RESUME:                   state_d = ST_RUN;
            default:                     state_d = ST_RUN;
        endcase
    end

    always_ff @(posedge clk) begin
        if (por_i) begin
            state_q <= ST_RUN;
            cause_q <= WK_NONE;
        end else begin
            state_q <= state_d;
            if (wake) cause_q <= det_cause;
        end
    end

    assign sys_osc_en_o = (state_q != ST_HALT);
    assign cpu_run_o    = (state_q == ST_RUN);
    assign warm_rst_o   = (state_q == ST_RESUME) && (cause_q == WK_WDT);
    assign irq_take_o   = (state_q == ST_RESUME) && (cause_q == WK_IRQ_VEC);

    // R1: an accepted halt stops oscillator and CPU and sets flags 0,1
    p_halt_entry_r1: assert property (@(posedge clk) disable iff (por_i)
        halt_go |=> (!sys_osc_en_o && !cpu_run_o && flag_pd_o && !flag_to_o));

    // R3: overflow together with halt keeps the CPU running
    p_ovf_beats_halt_r3: assert property (@(posedge clk) disable iff (por_i)
        (cpu_run_o && halt_cmd_i && wdt_ovf_i) |=> (cpu_run_o && flag_to_o));

    // R4: external reset while running changes nothing here
    p_ext_run_ignored_r4: assert property (@(posedge clk) disable iff (por_i)
        (cpu_run_o && ext_rst_i && !halt_cmd_i && !wdt_ovf_i && !wdt_clr_i)
        |=> (cpu_run_o && $stable(flag_to_o) && $stable(flag_pd_o)));

    // R10: resume is only reached through the delay
    p_resume_after_delay_r10: assert property (@(posedge clk) disable iff (por_i)
        (state_q == ST_RESUME) |-> ($past(state_q) == ST_WAKE_DELAY));

    // R12: the two pulses exclude each other
    p_pulse_excl_r12: assert property (@(posedge clk) disable iff (por_i)
        !(warm_rst_o && irq_take_o));

    // R12: the CPU runs right after a pulse
    p_pulse_then_run_r12: assert property (@(posedge clk) disable iff (por_i)
        (warm_rst_o || irq_take_o) |=> cpu_run_o);

endmodule

// File: tb/halt_wake_ctrl_tb.sv
module halt_wake_ctrl_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int IRQ_N = 4;
    localparam int PA_W  = 8;
    localparam int PG_N  = 3;
    localparam int PG_W  = 8;
    localparam int DLY   = 1024;

    logic clk = 1'b0;
    logic por = 1'b1;
    logic ext_rst = 0, halt_cmd = 0, wdt_clr = 0, wdt_ovf = 0, stack_full = 0;
    logic [IRQ_N-1:0]     irq_req = '0, irq_en = '0;
    logic [PA_W-1:0]      pa = '0, pa_en = '0;
    logic [PG_N*PG_W-1:0] pg = '0;
    logic [PG_N-1:0]      pg_en = '0;
    logic osc_en, cpu_run, warm_rst, irq_take, f_to, f_pd;

    int n_checks = 0;
    int n_fail   = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    halt_wake_ctrl #(
        .IRQ_N(IRQ_N), .PA_W(PA_W), .PG_N(PG_N), .PG_W(PG_W), .DELAY_CYC(DLY)
    ) dut_i (
        .clk(clk), .por_i(por), .ext_rst_i(ext_rst), .halt_cmd_i(halt_cmd),
        .wdt_clr_i(wdt_clr), .wdt_ovf_i(wdt_ovf), .irq_req_i(irq_req),
        .irq_en_i(irq_en), .stack_full_i(stack_full), .pa_i(pa),
        .pa_wake_en_i(pa_en), .pg_i(pg), .pg_wake_en_i(pg_en),
        .sys_osc_en_o(osc_en), .cpu_run_o(cpu_run), .warm_rst_o(warm_rst),
        .irq_take_o(irq_take), .flag_to_o(f_to), .flag_pd_o(f_pd)
    );

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic check(input string tag, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    endtask

    // Codes: 0 none, 1 external reset, 2 watchdog, 3 take vector, 4 continue
    function automatic int exp_wake(input logic e, input logic w,
                                    input logic [IRQ_N-1:0] nirq,
                                    input logic [IRQ_N-1:0] en,
                                    input logic sf, input logic port_fall);
        if (e) return 1;
        if (w) return 2;
        if (nirq != '0) return ((nirq & en) != '0 && !sf) ? 3 : 4;
        if (port_fall) return 4;
        return 0;
    endfunction

    function automatic logic exp_port(input logic [PA_W-1:0] a_old, a_new, a_en,
                                      input logic [PG_N*PG_W-1:0] g_old, g_new,
                                      input logic [PG_N-1:0] g_en);
        logic f = |(a_old & ~a_new & a_en);
        for (int g = 0; g < PG_N; g++)
            if (g_en[g] && ((g_old[g*PG_W +: PG_W] & ~g_new[g*PG_W +: PG_W]) != '0)) f = 1'b1;
        return f;
    endfunction

    task automatic enter_halt();
        halt_cmd = 1; step(); halt_cmd = 0;
        check("R1 osc off", osc_en, 0);
        check("R1 cpu stop", cpu_run, 0);
        check("R1 pd set", f_pd, 1);
        check("R1 to clear", f_to, 0);
    endtask

    // Called right after the wake edge; verifies the delay and the pulses.
    task automatic finish_wake(input int code);
        int n = 0, pulse_at = -1;
        logic saw_warm = 0, saw_take = 0;
        check("R10 osc on during delay", osc_en, 1);
        check("R10 cpu held", cpu_run, 0);
        while (!cpu_run && n < 3000) begin
            if (warm_rst) begin saw_warm = 1; pulse_at = n; end
            if (irq_take) begin saw_take = 1; pulse_at = n; end
            step(); n++;
        end
        check("R10 run after delay", n, DLY + 1);
        check("R6 warm pulse", saw_warm, code == 2);
        check("R9 vector pulse", saw_take, code == 3);
        if (code == 2 || code == 3) check("R12 pulse in resume cycle", pulse_at, DLY);
        check("R5 R6 timeout flag", f_to, code == 2);
        check("R5 pd flag kept", f_pd, 1);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual running expected finished");
        summary();
        $finish;
    end

    initial begin
        void'($urandom(32'd1357));
        repeat (3) step();
        por = 0;
        // R11: power-on state
        check("R11 to", f_to, 0);
        check("R11 pd", f_pd, 0);
        check("R11 osc", osc_en, 1);
        check("R11 run", cpu_run, 1);
        check("R11 pulses", warm_rst | irq_take, 0);

        // R4: external reset while running
        ext_rst = 1; step(); ext_rst = 0;
        check("R4 run kept", cpu_run, 1);
        check("R4 flags kept", {f_to, f_pd}, 0);

        // R3: halt and overflow together, overflow wins
        halt_cmd = 1; wdt_ovf = 1; step(); halt_cmd = 0; wdt_ovf = 0;
        check("R3 still running", cpu_run, 1);
        check("R3 to set", f_to, 1);
        check("R3 pd unchanged", f_pd, 0);

        // Halt, then external reset and watchdog together: reset wins (R5)
        enter_halt();
        ext_rst = 1; wdt_ovf = 1; step(); ext_rst = 0; wdt_ovf = 0;
        finish_wake(1);

        // R3: overflow while running keeps pd
        wdt_ovf = 1; step(); wdt_ovf = 0;
        check("R3 to set in run", f_to, 1);
        check("R3 pd stays 1", f_pd, 1);
        // R2: clear drops pd, keeps to
        wdt_clr = 1; step(); wdt_clr = 0;
        check("R2 pd cleared", f_pd, 0);
        check("R2 to kept", f_to, 1);
        // R2: clear together with halt, halt wins
        wdt_clr = 1; halt_cmd = 1; step(); wdt_clr = 0; halt_cmd = 0;
        check("R2 halt beats clear pd", f_pd, 1);
        check("R2 halted", cpu_run, 0);
        // R7: disabled pin edge and enabled rising edge do not wake
        pa = 8'h01; pa_en = 8'h02; step(); step();
        pa = 8'h00; step(); step();
        check("R7 disabled edge ignored", osc_en, 0);
        pa = 8'h02; step(); step();
        check("R7 rising edge ignored", osc_en, 0);
        // R8: a request pending at entry - raise one now, it is new
        irq_req = 4'b0100; irq_en = 4'b0100; step();
        finish_wake(3);
        // R8: pending at entry never wakes
        enter_halt();
        repeat (4) step();
        check("R8 pending ignored", osc_en, 0);
        // R7: enabled first-port pin falling wakes
        pa = 8'h00; step();
        finish_wake(4);
        irq_req = '0; step();

        // Random phase
        for (int it = 0; it < 30; it++) begin
            logic [PA_W-1:0] a0, a1;
            logic [PG_N*PG_W-1:0] g0, g1;
            logic [IRQ_N-1:0] pend, nirq;
            logic e, w, pf;
            int code;
            a0 = PA_W'($urandom); g0 = (PG_N*PG_W)'($urandom);
            pa = a0; pg = g0;
            pa_en = PA_W'($urandom); pg_en = PG_N'($urandom);
            irq_en = IRQ_N'($urandom);
            pend = IRQ_N'($urandom); irq_req = pend;
            step(); step();
            enter_halt();
            step();
            e = ($urandom_range(0, 7) == 0);
            w = ($urandom_range(0, 5) == 0);
            nirq = ($urandom_range(0, 2) == 0) ? (IRQ_N'($urandom) & ~pend) : '0;
            a1 = ($urandom_range(0, 1) == 0) ? PA_W'($urandom) : a0;
            g1 = ($urandom_range(0, 1) == 0) ? (PG_N*PG_W)'($urandom) : g0;
            stack_full = $urandom_range(0, 1);
            pf = exp_port(a0, a1, pa_en, g0, g1, pg_en);
            code = exp_wake(e, w, nirq, irq_en, stack_full, pf);
            ext_rst = e; wdt_ovf = w; irq_req = pend | nirq; pa = a1; pg = g1;
            step();
            ext_rst = 0; wdt_ovf = 0;
            if (code == 0) begin
                repeat (3) step();
                check("R7 R8 no wake", osc_en, 0);
                ext_rst = 1; step(); ext_rst = 0;
                code = 1;
            end
            finish_wake(code);
            irq_req = '0; stack_full = 0;
        end

        summary();
        $finish;
    end
endmodule